// File: doc/BRIEF.md
# Sliding-Scale Offset Corrector

This block is the digital side of a sliding-scale scheme that flattens the bin-width spread of a 13-bit peak-sensing converter. It drives a 6-bit offset code to an external DAC. The DAC pulls the analogue peak down by that many converter steps before digitisation. The block then restores the same amount in the digital domain. Each pulse therefore lands on a different set of converter bins over time, and the bin-width errors average out across 64 positions.

The shift is applied downward so that a full-scale peak never overloads the converter. Restoring it means adding the code to the raw result. Two cases are flagged. A sum that exceeds the 13-bit range is clamped and marked as overflow. A raw result of zero taken under a non-zero code means the pulse was too small and the shift drove it below zero, so it is marked as underflow.

Top module: `sls_corr_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, dac_code_o is 0 and corr_valid_o, ovf_o and unf_o are 0.
- R2: Every cycle with raw_valid_i high advances dac_code_o by one on the next clock, and 63 wraps to 0.
- R3: In a cycle with raw_valid_i low, dac_code_o keeps its value on the next clock.
- R4: The corrected value corr_o equals raw_i plus the dac_code_o value present in the cycle raw_valid_i was high. It is straight binary, 0 to 8191.
- R5: corr_valid_o is high in exactly the cycle after each raw_valid_i cycle, and is low otherwise. Back-to-back inputs give back-to-back results.
- R6: When raw_i plus the code exceeds 8191, corr_o is 8191 and ovf_o is 1. When the sum is 8191 or less, ovf_o is 0.
- R7: unf_o is 1 with a result exactly when raw_i was 0 and the code used was non-zero. A zero raw value under code 0 is not flagged.
- R8: ovf_o and unf_o are 0 in every cycle in which corr_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 13 | Raw conversion result |
| raw_valid_i | input | 1 | Raw result strobe, one cycle per conversion |
| dac_code_o | output | 6 | Offset code applied by the external DAC |
| corr_o | output | 13 | Corrected conversion value |
| corr_valid_o | output | 1 | corr_o and flags valid |
| ovf_o | output | 1 | Sum clamped to full scale |
| unf_o | output | 1 | Raw zero under a non-zero code |

## Verification
A mid-range sweep runs a full 64-step cycle of the code with varied raw values. It separates a correct add from a subtract or a stale code, and it proves the wrap from 63 to 0. Idle gaps between strobes show that the code does not move without a conversion. Back-to-back strobes show that the one-cycle latency holds under streaming. Raw values of 8191, near full scale, zero, and exact-fit sums separate the clamp boundary and the underflow rule, including zero under code 0.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int unsigned RAW_W_DEF  = 13;
  localparam int unsigned CODE_W_DEF = 6;

  typedef struct packed {
    logic ovf;
    logic unf;
  } sls_flags_t;
endpackage

// File: rtl/sls_offset_gen.sv
module sls_offset_gen #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (adv_i) code_q <= code_q + 1'b1; // wraps modulo 2**CODE_W
  end

  assign code_o = code_q;

  AST_CODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> code_o == CODE_W'($past(code_o) + 1'b1)); // R2
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(code_o)); // R3
endmodule

// File: rtl/sls_correct.sv
module sls_correct
  import sls_pkg::*;
#(
  parameter int unsigned RAW_W  = 13,
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [RAW_W-1:0]  res_o,
  output logic              valid_o,
  output sls_flags_t        flags_o
);
  localparam int unsigned SUM_W = RAW_W + 1;
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'((1 << RAW_W) - 1);

  logic [SUM_W-1:0] sum;
  logic [RAW_W-1:0] res_d;
  sls_flags_t       flg_d;
  logic [RAW_W-1:0] res_q;
  logic             valid_q;
  sls_flags_t       flg_q;

  // negative analogue shift: restore by adding the code back
  always_comb begin
    sum       = {1'b0, raw_i} + SUM_W'(code_i);
    flg_d.ovf = sum > MAX_SUM;
    flg_d.unf = (raw_i == '0) && (code_i != '0);
    res_d     = flg_d.ovf ? MAX_SUM[RAW_W-1:0] : sum[RAW_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_i;
      flg_q   <= valid_i ? flg_d : '0;
      if (valid_i) res_q <= res_d;
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;
  assign flags_o = flg_q;

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R5
  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.ovf |-> res_o == MAX_SUM[RAW_W-1:0]); // R6
  AST_FLAGS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !flags_o.ovf && !flags_o.unf); // R8
  AST_UNF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.unf |-> (res_o != '0) && (res_o < RAW_W'(1 << CODE_W))); // R7
  AST_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !flg_d.ovf |=> res_o == $past(raw_i) + RAW_W'($past(code_i))); // R4
endmodule

// File: rtl/sls_corr_unit.sv
module sls_corr_unit
  import sls_pkg::*;
#(
  parameter int unsigned RAW_W  = RAW_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic              raw_valid_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [RAW_W-1:0]  corr_o,
  output logic              corr_valid_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [CODE_W-1:0] code;
  sls_flags_t        flags;

  sls_offset_gen #(.CODE_W(CODE_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (raw_valid_i),
    .code_o (code)
  );

  sls_correct #(.RAW_W(RAW_W), .CODE_W(CODE_W)) u_corr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw_i),
    .valid_i (raw_valid_i),
    .code_i  (code),
    .res_o   (corr_o),
    .valid_o (corr_valid_o),
    .flags_o (flags)
  );

  assign dac_code_o = code;
  assign ovf_o      = flags.ovf;
  assign unf_o      = flags.unf;

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> dac_code_o == '0 && !corr_valid_o); // R1
endmodule

// File: tb/tb_sls_corr_unit.sv
`timescale 1ns/1ps
module tb_sls_corr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] raw_i = '0;
  logic        raw_valid_i = 1'b0;
  logic [5:0]  dac_code_o;
  logic [12:0] corr_o;
  logic        corr_valid_o, ovf_o, unf_o;

  int n_run = 0, n_fail = 0;
  int exp_code = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sls_corr_unit dut (.*);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobe, then check result a cycle later; gap cycles follow
  task automatic conv(int raw, int gap);
    int s, ec;
    @(negedge clk_i);
    check("R3 code before strobe", dac_code_o, exp_code);
    raw_i = 13'(raw); raw_valid_i = 1'b1;
    s = raw + exp_code;
    ec = exp_code;
    @(negedge clk_i);
    raw_valid_i = 1'b0;
    check("R5 valid", corr_valid_o, 1);
    check("R4/R6 value", corr_o, (s > 8191) ? 8191 : s);
    check("R6 ovf", ovf_o, (s > 8191) ? 1 : 0);
    check("R7 unf", unf_o, (raw == 0 && ec != 0) ? 1 : 0);
    exp_code = (exp_code + 1) % 64;
    check("R2 step", dac_code_o, exp_code);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk_i);
      check("R5 idle valid", corr_valid_o, 0);
      check("R8 flags idle", ovf_o | unf_o, 0);
      check("R3 hold", dac_code_o, exp_code);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check("R1 code in reset", dac_code_o, 0);
    check("R1 valid in reset", corr_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 code after reset", dac_code_o, 0);
    check("R1 flags after reset", {corr_valid_o, ovf_o, unf_o}, 0);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 64; k++) conv(100 + k * 97, 0); // wraps code 63->0
    check("R2 wrap", dac_code_o, 0);
  endtask

  task automatic t_gaps();
    conv(1234, 3);
    conv(4000, 5);
  endtask

  task automatic t_overflow();
    while (exp_code != 40) conv(500, 0);
    conv(8191, 1);      // code 40: clamp
    conv(8151, 1);      // code 41: 8192 -> clamp
    conv(8149, 1);      // code 42: exactly 8191, no ovf
    conv(8100, 1);      // code 43: fits
  endtask

  task automatic t_underflow();
    while (exp_code != 0) conv(10, 0);
    conv(0, 1);         // code 0: no flag
    conv(0, 1);         // code 1: flag
    conv(1, 1);         // code 2: non-zero raw, no flag
    conv(0, 1);         // code 3: flag
  endtask

  task automatic t_burst();
    int raws[4] = '{300, 0, 8190, 7};
    int codes[4];
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      codes[i] = exp_code;
      raw_i = 13'(raws[i]); raw_valid_i = 1'b1;
      @(negedge clk_i);
      exp_code = (exp_code + 1) % 64;
      begin
        int s = raws[i] + codes[i];
        check("R5 burst valid", corr_valid_o, 1);
        check("R4 burst value", corr_o, (s > 8191) ? 8191 : s);
        check("R6 burst ovf", ovf_o, (s > 8191) ? 1 : 0);
        check("R7 burst unf", unf_o, (raws[i] == 0 && codes[i] != 0) ? 1 : 0);
        check("R2 burst step", dac_code_o, exp_code);
      end
    end
    raw_valid_i = 1'b0;
    @(negedge clk_i);
    check("R5 burst end", corr_valid_o, 0);
    check("R8 burst end flags", ovf_o | unf_o, 0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_gaps();
    t_overflow();
    t_underflow();
    t_burst();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule